// File: doc/BRIEF.md
# Processor Reset Initialization Sequencer

This block models how a processor core comes out of reset. While the reset input is high, all activity is abandoned and the sequencer sits idle. When reset drops, the sequencer starts its half-rate internal clock in a known phase and samples a busy input once to decide whether a built-in self-test should run. If the test runs, the sequencer counts out its full length. In either case it then waits a fixed number of fast-clock cycles and raises a one-cycle request to fetch the first instruction from the fixed top-of-memory vector.

All timing is counted in fast-clock cycles (`clk`). The reset input is treated as a level that is synchronous to `clk`. The falling edge of reset is the `clk` edge that first samples `rst_in` low after it was high. That edge is called the release edge below, and cycle n is the cycle after the n-th edge following it (cycle 0 follows the release edge itself). The self-test length and the fetch delay are parameters. The fetch delay is held inside the 350 to 450 cycle window: a value below that window is raised to 350, and a value above it is lowered to 450.

Top module: `rst_init_seq`

## Requirements
- R1: While `rst_in` is high, the cycle after each edge shows `st_active`=0, `fetch_req`=0, `done`=0, `fetch_addr`=0 and `half_clk`=1. Raising `rst_in` in the middle of a sequence aborts it on the next edge.
- R2: `half_clk` is 0 in cycle 0 after the release edge, so its falling edge lines up with the first fast cycle after reset falls. It then inverts on every edge until reset returns.
- R3: `busy_n` is sampled only at the release edge. A low level (0) selects self-test and a high level (1) skips it. Changes of `busy_n` at any other time have no effect on `st_active` or on the fetch timing.
- R4: When self-test is selected, `st_active` is 1 for exactly `ST_CYCLES` consecutive cycles (cycles 0 to `ST_CYCLES`-1; default 2^20+60). The sequence then goes on, since no test outcome is ever examined.
- R5: `fetch_req` is first high in cycle D without self-test, or in cycle `ST_CYCLES`+D with self-test. D is `FETCH_DELAY` clamped into the range 350 to 450 (default 400).
- R6: While `fetch_req` is 1, `fetch_addr` equals `RESET_VECTOR` (default 32'hFFFF_FFF0). At all other times it is 0.
- R7: `fetch_req` is high for exactly one cycle per reset release. `done` rises in the cycle after it and stays 1 until `rst_in` is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all timing counts its cycles |
| rst_in | input | 1 | Active-high reset level, synchronous to `clk` |
| busy_n | input | 1 | Sampled at the release edge; low requests self-test |
| half_clk | output | 1 | Internal half-rate clock phase |
| st_active | output | 1 | High while the self-test runs |
| fetch_req | output | 1 | One-cycle first-fetch request strobe |
| fetch_addr | output | ADDR_W | Fetch address, valid with `fetch_req` |
| done | output | 1 | Initialization finished; sticky until reset |

## Verification
The assertions assume that `rst_in` and `busy_n` are synchronous to `clk` and settle well before each rising edge. They also assume that `rst_in` is high at the first edge, so the sequencer starts from a defined idle state. The stimulus changes every input only at falling clock edges and opens each run with a reset phase of several cycles. The bench toggles `busy_n` freely after the release edge to show that it is ignored there.

// File: rtl/rst_init_pkg.sv
package rst_init_pkg;

  typedef enum logic [1:0] {
    RESET_HOLD = 2'd0,
    SELF_TEST  = 2'd1,
    INIT_WAIT  = 2'd2,
    FETCH      = 2'd3
  } seq_state_e;

  localparam int unsigned DLY_MIN = 350;
  localparam int unsigned DLY_MAX = 450;

  // Keep the requested fetch delay inside its legal window.
  function automatic int unsigned clamp_delay(input int unsigned req);
    if (req < DLY_MIN) return DLY_MIN;
    if (req > DLY_MAX) return DLY_MAX;
    return req;
  endfunction

  // Counter width able to hold the larger of two cycle counts.
  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/rst_edge_det.sv
module rst_edge_det (
  input  logic clk,
  input  logic rst_in,
  output logic fall_o
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst_in;
  end

  assign fall_o = rst_q & ~rst_in;
endmodule

// File: rtl/half_clk_gen.sv
module half_clk_gen (
  input  logic clk,
  input  logic hold,
  output logic phase_o
);
  logic ph_q;

  // Held high in reset so the first edge after release is a falling one.
  always_ff @(posedge clk) begin
    if (hold) ph_q <= 1'b1;
    else      ph_q <= ~ph_q;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import rst_init_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] ST_LOAD  = '0,
  parameter logic [W-1:0] DLY_LOAD = '0
) (
  input  logic         clk,
  input  logic         rst_in,
  input  logic         fall,
  input  logic         busy_n,
  input  logic         tmr_zero,
  output seq_state_e   state_o,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         st_active,
  output logic         fetch_req,
  output logic         done
);
  seq_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      RESET_HOLD: begin
        if (fall) begin
          tmr_load = 1'b1;
          if (!busy_n) begin
            state_d = SELF_TEST;
            tmr_val = ST_LOAD;
          end else begin
            state_d = INIT_WAIT;
            tmr_val = DLY_LOAD;
          end
        end
      end
      SELF_TEST: begin
        if (tmr_zero) begin
          state_d  = INIT_WAIT;
          tmr_load = 1'b1;
          tmr_val  = DLY_LOAD;
        end
      end
      INIT_WAIT: begin
        if (tmr_zero) state_d = FETCH;
      end
      FETCH: state_d = FETCH;
      default: state_d = RESET_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_in) begin
      state_q <= RESET_HOLD;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == FETCH) done_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign st_active = (state_q == SELF_TEST);
  assign fetch_req = (state_q == FETCH) && !done_q;
  assign done      = done_q;
endmodule

// File: rtl/rst_init_seq.sv
module rst_init_seq
  import rst_init_pkg::*;
#(
  parameter int unsigned ST_CYCLES   = (1 << 20) + 60,
  parameter int unsigned FETCH_DELAY = 400,
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] RESET_VECTOR = ADDR_W'(32'hFFFF_FFF0)
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic              busy_n,
  output logic              half_clk,
  output logic              st_active,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              done
);
  localparam int unsigned DLY_EFF = clamp_delay(FETCH_DELAY);
  localparam int unsigned ST_EFF  = (ST_CYCLES < 1) ? 1 : ST_CYCLES;
  localparam int unsigned CW      = cnt_bits(ST_EFF, DLY_EFF);
  localparam logic [CW-1:0] ST_LOAD  = CW'(ST_EFF - 1);
  localparam logic [CW-1:0] DLY_LOAD = CW'(DLY_EFF - 1);

  logic          fall_evt;
  logic          tmr_zero;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  seq_state_e    state_q;

  rst_edge_det u_edge (
    .clk    (clk),
    .rst_in (rst_in),
    .fall_o (fall_evt)
  );

  half_clk_gen u_phase (
    .clk     (clk),
    .hold    (rst_in),
    .phase_o (half_clk)
  );

  seq_timer #(.W(CW)) u_tmr (
    .clk      (clk),
    .clr      (rst_in),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero_o   (tmr_zero)
  );

  seq_fsm #(.W(CW), .ST_LOAD(ST_LOAD), .DLY_LOAD(DLY_LOAD)) u_fsm (
    .clk       (clk),
    .rst_in    (rst_in),
    .fall      (fall_evt),
    .busy_n    (busy_n),
    .tmr_zero  (tmr_zero),
    .state_o   (state_q),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .st_active (st_active),
    .fetch_req (fetch_req),
    .done      (done)
  );

  assign fetch_addr = fetch_req ? RESET_VECTOR : '0;
endmodule

// File: rtl/rst_init_chk.sv
module rst_init_chk
  import rst_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VECTOR = '0
) (
  input logic              clk,
  input logic              rst_in,
  input logic              busy_n,
  input logic              half_clk,
  input logic              st_active,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              done,
  input logic              fall_evt,
  input seq_state_e        state_q
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst_in) seen_rst <= 1'b1;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!seen_rst)
    rst_in |=> (state_q == RESET_HOLD && !st_active && !fetch_req && !done && half_clk)); // R1

  AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (rst_in)
    fall_evt |=> !half_clk); // R2

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst_in)
    !rst_in |=> (half_clk != $past(half_clk))); // R2

  AST_TEST_SELECT: assert property (@(posedge clk) disable iff (rst_in)
    (fall_evt && !busy_n) |=> st_active); // R3

  AST_NO_TEST_SELECT: assert property (@(posedge clk) disable iff (rst_in)
    (fall_evt && busy_n) |=> !st_active); // R3

  AST_TEST_EXIT: assert property (@(posedge clk) disable iff (rst_in)
    ($fell(st_active) && !$past(rst_in)) |-> (state_q == INIT_WAIT)); // R4

  AST_FETCH_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst_in)
    $rose(fetch_req) |-> ($past(state_q) == INIT_WAIT)); // R5

  AST_VECTOR: assert property (@(posedge clk) disable iff (rst_in)
    fetch_req |-> (fetch_addr == RESET_VECTOR)); // R6

  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst_in)
    !fetch_req |-> (fetch_addr == '0)); // R6

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst_in)
    fetch_req |=> (!fetch_req && done)); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst_in)
    done |=> done); // R7
endmodule

bind rst_init_seq rst_init_chk #(.ADDR_W(ADDR_W), .RESET_VECTOR(RESET_VECTOR)) u_chk (
  .clk        (clk),
  .rst_in     (rst_in),
  .busy_n     (busy_n),
  .half_clk   (half_clk),
  .st_active  (st_active),
  .fetch_req  (fetch_req),
  .fetch_addr (fetch_addr),
  .done       (done),
  .fall_evt   (fall_evt),
  .state_q    (state_q)
);

// File: tb/tb_rst_init_seq.sv
`timescale 1ns/100ps
module tb_rst_init_seq;
  localparam int unsigned ST  = 120;
  localparam int unsigned D1  = 400;   // dut: default delay
  localparam int unsigned D2  = 350;   // dut2: 300 requested, raised to 350
  localparam logic [31:0] VEC = 32'hFFFF_FFF0;

  logic clk = 1'b0;
  logic rst_in = 1'b1;
  logic busy_n = 1'b1;
  logic half_clk, st_active, fetch_req, done;
  logic [31:0] fetch_addr;
  logic half_clk2, st_active2, fetch_req2, done2;
  logic [31:0] fetch_addr2;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rst_init_seq #(.ST_CYCLES(ST)) dut (
    .clk(clk), .rst_in(rst_in), .busy_n(busy_n), .half_clk(half_clk),
    .st_active(st_active), .fetch_req(fetch_req), .fetch_addr(fetch_addr), .done(done)
  );

  rst_init_seq #(.ST_CYCLES(ST), .FETCH_DELAY(300)) dut2 (
    .clk(clk), .rst_in(rst_in), .busy_n(busy_n), .half_clk(half_clk2),
    .st_active(st_active2), .fetch_req(fetch_req2), .fetch_addr(fetch_addr2), .done(done2)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_reset(input int n);
    @(negedge clk);
    rst_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // R1: idle outputs while reset is high
  task automatic t_reset_state();
    hold_reset(6);
    chk(st_active == 1'b0, "R1 st_active in reset", st_active, 0);
    chk(fetch_req == 1'b0, "R1 fetch_req in reset", fetch_req, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(fetch_addr == 32'h0, "R1 fetch_addr in reset", fetch_addr, 0);
    chk(half_clk == 1'b1, "R1 half_clk in reset", half_clk, 1);
  endtask

  // One full boot; checks R2..R7 against both instances.
  task automatic t_boot(input bit bsy, input bit toggle_busy, input string name);
    int exp_st, f1, f2, n1, n2, st_cnt, last;
    bit addr_ok;
    exp_st = bsy ? 0 : ST;
    f1 = -1; f2 = -1; n1 = 0; n2 = 0; st_cnt = 0; addr_ok = 1'b1;
    last = exp_st + D1 + 3;
    hold_reset(20);
    busy_n = bsy;
    rst_in = 1'b0;
    @(posedge clk);
    for (int n = 0; n <= last; n++) begin
      @(negedge clk);
      if (toggle_busy) busy_n = ~busy_n;
      if (n < 6) chk(half_clk == n[0], {"R2 half_clk phase ", name}, half_clk, n[0]);
      if (st_active) st_cnt++;
      if (fetch_req) begin
        n1++;
        if (f1 < 0) f1 = n;
        if (fetch_addr != VEC) addr_ok = 1'b0;
      end else if (fetch_addr != 32'h0) addr_ok = 1'b0;
      if (fetch_req2) begin
        n2++;
        if (f2 < 0) f2 = n;
      end
      if (n == 0) chk(st_active == !bsy, {"R3 self-test choice ", name}, st_active, !bsy);
      if (n == exp_st + D1) chk(done == 1'b0, {"R7 done before strobe ", name}, done, 0);
      if (n == exp_st + D1 + 1) chk(done == 1'b1, {"R7 done after strobe ", name}, done, 1);
    end
    chk(st_cnt == exp_st, {"R4 self-test length ", name}, st_cnt, exp_st);
    chk(f1 == exp_st + D1, {"R5 fetch cycle ", name}, f1, exp_st + D1);
    chk(f2 == exp_st + D2, {"R5 clamped fetch cycle ", name}, f2, exp_st + D2);
    chk(addr_ok, {"R6 fetch address ", name}, addr_ok, 1);
    chk(n1 == 1, {"R7 single strobe ", name}, n1, 1);
    chk(n2 == 1, {"R7 single strobe dut2 ", name}, n2, 1);
    chk(done == 1'b1 && done2 == 1'b1, {"R7 done sticky ", name}, done, 1);
  endtask

  // R1: raising reset mid self-test aborts at once
  task automatic t_abort();
    hold_reset(20);
    busy_n = 1'b0;
    rst_in = 1'b0;
    repeat (30) @(negedge clk);
    chk(st_active == 1'b1, "R4 self-test running before abort", st_active, 1);
    rst_in = 1'b1;
    @(negedge clk);
    chk(st_active == 1'b0, "R1 abort clears self-test", st_active, 0);
    chk(half_clk == 1'b1, "R1 abort holds half_clk", half_clk, 1);
    chk(done == 1'b0 && fetch_req == 1'b0, "R1 abort idle", done, 0);
  endtask

  initial begin
    t_reset_state();
    t_boot(1'b1, 1'b0, "no-test");
    t_reset_state();                 // done cleared by reset again
    t_boot(1'b0, 1'b0, "test");
    t_boot(1'b0, 1'b1, "test busy toggling");   // R3 later busy ignored
    t_abort();
    t_boot(1'b1, 1'b1, "no-test busy toggling"); // R3
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule